// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Node

This block is the interrupt logic that one peripheral contributes to a priority chain on an 8-bit processor bus. Nodes are wired in series: each node's enable output feeds the enable input of the next, lower-priority node. A node that holds a waiting request, or whose request is still being serviced, blocks the chain below it. A node that holds neither passes its enable input straight through.

The node watches the active-low bus strobes. An interrupt acknowledge is the cycle in which the opcode-fetch strobe (M1) and the I/O strobe (IORQ) are low together. During the acknowledge, the node that still sees its chain enable high and has a request waiting places a fixed 8-bit vector on the data bus. It then moves that request from waiting to in-service. The chain status is frozen while M1 is low, so every node sees the same stable winner. A new request that arrives in that window is parked in a shadow flag and takes effect once M1 is high again. A one-cycle return-from-interrupt pulse releases the in-service latch, but only in the node whose chain enable is still high. That node is the highest-priority one in service.

Top module: `irq_chain_node`

## Requirements
- R1: While `rst_n` is low at a clock edge, the waiting and in-service flags clear. After that edge, `ieo_o` equals `iei_i`, `int_n_o` is high and `vec_oe_o` is low.
- R2: A `req_i` sampled high at an edge where `m1_n_i` is high sets the waiting flag `pend_o` after that edge. `int_n_o` is low exactly while `pend_o` is high and `iei_i` is high.
- R3: With `pend_o` and `insvc_o` both low, `ieo_o` follows `iei_i`.
- R4: With `pend_o` or `insvc_o` high, `ieo_o` is low for any `iei_i`.
- R5: An acknowledge is `m1_n_i` low and `iorq_n_i` low. `vec_oe_o` is high only during an acknowledge with `rd_n_i` high and `iei_i` high, and only in the node that won it. While `vec_oe_o` is high, `vec_o` equals the parameter `VECTOR`; otherwise `vec_o` is zero.
- R6: The first clock edge of an acknowledge that sees `iei_i` high, `rd_n_i` high and `pend_o` high sets `insvc_o` and clears `pend_o`. The node keeps `vec_oe_o` high for the rest of that acknowledge.
- R7: Across any edge where `m1_n_i` is low, the value of `pend_o | insvc_o` does not change. A request sampled in that window sets `pend_o` at the first edge where `m1_n_i` is high.
- R8: A `reti_i` pulse clears `insvc_o` at an edge only if `m1_n_i` and `iei_i` are both high. Otherwise the pulse has no effect.
- R9: A node that sees `iei_i` low, or `rd_n_i` low, or has no waiting request during an acknowledge keeps `vec_oe_o` low and its flags unchanged.
- R10: A request parked during the acknowledge that serves the same node becomes waiting again. If a release falls on that same edge, the node ends with `pend_o` high and `insvc_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Local interrupt request, sampled each edge |
| iei_i | input | 1 | Chain enable from the higher-priority neighbour |
| m1_n_i | input | 1 | Opcode-fetch strobe, active low |
| iorq_n_i | input | 1 | I/O request strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| reti_i | input | 1 | One-cycle return-from-interrupt pulse |
| ieo_o | output | 1 | Chain enable to the lower-priority neighbour |
| int_n_o | output | 1 | Interrupt request to the processor, active low, for wired-AND |
| vec_o | output | VEC_W | Interrupt vector, zero when not driving |
| vec_oe_o | output | 1 | Vector output enable for the data bus |
| pend_o | output | 1 | Waiting-request flag |
| insvc_o | output | 1 | In-service flag |

## Verification
Two functions can land on the same clock edge. The first pair is a new local request and the acknowledge that serves the same node. The second pair is a parked request reaching the waiting flag and a return-from-interrupt releasing that node. The bench sets both up in a three-node chain: it raises a node's request inside the acknowledge that serves it, then sends the release on the first cycle after M1 goes high. It then checks that the node ends up waiting and not in service, with its interrupt output low. A repeat acknowledge must then hand it the bus again.

// File: rtl/irq_chain_pkg.sv
// Package: shared types for the interrupt chain node.
// Assumes: bus strobes arrive already synchronous to clk.
package irq_chain_pkg;

    // Decoded state of the processor bus strobes in one cycle
    typedef struct packed {
        logic frozen;   // M1 low: chain status must hold
        logic ack;      // M1 and IORQ low together
        logic rd_idle;  // RD high, the read strobe is not active
    } bus_phase_t;

endpackage

// File: rtl/irq_bus_phase.sv
// Module: irq_bus_phase
// Decodes the active-low bus strobes into the cycle phase used by the node.
// Assumes: inputs are stable around the rising clock edge.
module irq_bus_phase
    import irq_chain_pkg::*;
(
    input  logic       m1_n_i,
    input  logic       iorq_n_i,
    input  logic       rd_n_i,
    output bus_phase_t phase_o
);

    // Combine the strobes into the phase struct
    always_comb begin
        phase_o.frozen  = ~m1_n_i;
        phase_o.ack     = ~m1_n_i & ~iorq_n_i;
        phase_o.rd_idle = rd_n_i;
    end

endmodule

// File: rtl/irq_req_capture.sv
// Module: irq_req_capture
// Holds off local requests while the chain is frozen. A request seen in the
// frozen window is parked in a shadow flag and released at the first unfrozen edge.
// Assumes: synchronous active-low reset.
module irq_req_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic frozen_i,
    output logic set_pend_o
);

    logic shadow_q;

    // Park requests that arrive while M1 is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= 1'b0;
        end else if (frozen_i) begin
            shadow_q <= shadow_q | req_i;
        end else begin
            shadow_q <= 1'b0;
        end
    end

    // Request to set the waiting flag, only outside the frozen window
    always_comb begin
        set_pend_o = ~frozen_i & (req_i | shadow_q);
    end

endmodule

// File: rtl/irq_svc_latch.sv
// Module: irq_svc_latch
// Waiting and in-service latches plus the grant flag that holds the vector
// enable for the whole acknowledge. A take moves waiting into service.
// Assumes: take_i occurs only while frozen, set_pend_i and release_i only outside it.
module irq_svc_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pend_i,
    input  logic take_i,
    input  logic release_i,
    input  logic ack_i,
    output logic pend_o,
    output logic insvc_o,
    output logic grant_o
);

    logic pend_q;
    logic insvc_q;
    logic grant_q;

    // Waiting latch: set by a new request, cleared when serviced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (take_i) begin
            pend_q <= 1'b0;
        end else if (set_pend_i) begin
            pend_q <= 1'b1;
        end
    end

    // In-service latch: set on winning an acknowledge, cleared on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insvc_q <= 1'b0;
        end else if (take_i) begin
            insvc_q <= 1'b1;
        end else if (release_i) begin
            insvc_q <= 1'b0;
        end
    end

    // Grant flag: remembers the win until the acknowledge ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
        end else begin
            grant_q <= ack_i & (take_i | grant_q);
        end
    end

    assign pend_o  = pend_q;
    assign insvc_o = insvc_q;
    assign grant_o = grant_q;

endmodule

// File: rtl/irq_chain_node.sv
// Module: irq_chain_node
// One node of a daisy-chained interrupt priority scheme. It raises an
// active-low interrupt, blocks the chain while it waits or is served, and
// drives its vector during an acknowledge it wins.
// Assumes: synchronous active-low reset; strobes synchronous to clk.
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter int               VEC_W  = 8,
    parameter logic [VEC_W-1:0] VECTOR = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             iei_i,
    input  logic             m1_n_i,
    input  logic             iorq_n_i,
    input  logic             rd_n_i,
    input  logic             reti_i,
    output logic             ieo_o,
    output logic             int_n_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_oe_o,
    output logic             pend_o,
    output logic             insvc_o
);

    bus_phase_t phase;
    logic       set_pend;
    logic       take;
    logic       release_svc;
    logic       pend;
    logic       insvc;
    logic       grant;

    irq_bus_phase u_phase (
        .m1_n_i   (m1_n_i),
        .iorq_n_i (iorq_n_i),
        .rd_n_i   (rd_n_i),
        .phase_o  (phase)
    );

    irq_req_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .frozen_i   (phase.frozen),
        .set_pend_o (set_pend)
    );

    // Win and release conditions for this node
    always_comb begin
        take        = phase.ack & phase.rd_idle & iei_i & pend;
        release_svc = reti_i & ~phase.frozen & iei_i;
    end

    irq_svc_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_pend_i (set_pend),
        .take_i     (take),
        .release_i  (release_svc),
        .ack_i      (phase.ack),
        .pend_o     (pend),
        .insvc_o    (insvc),
        .grant_o    (grant)
    );

    // Chain, interrupt and vector outputs
    always_comb begin
        ieo_o    = iei_i & ~pend & ~insvc;
        int_n_o  = ~(pend & iei_i);
        vec_oe_o = phase.ack & phase.rd_idle & iei_i & (pend | grant);
        vec_o    = vec_oe_o ? VECTOR : '0;
    end

    assign pend_o  = pend;
    assign insvc_o = insvc;

endmodule

// File: rtl/irq_chain_node_chk.sv
// Module: irq_chain_node_chk
// Property checker for irq_chain_node, bound to every instance.
// Assumes: the same clock and synchronous reset as the node.
module irq_chain_node_chk (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic iei_i,
    input logic m1_n_i,
    input logic iorq_n_i,
    input logic rd_n_i,
    input logic reti_i,
    input logic vec_oe_o,
    input logic pend_o,
    input logic insvc_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!pend_o && !insvc_o));

    // R2
    req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && m1_n_i) |=> pend_o);

    // R5
    oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> (!m1_n_i && !iorq_n_i && rd_n_i && iei_i));

    // R6
    take_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n_i && !iorq_n_i && rd_n_i && iei_i && pend_o) |=> (insvc_o && !pend_o));

    // R7
    frozen_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_n_i |=> $stable(pend_o || insvc_o));

    // R8
    reti_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_o && (!iei_i || !m1_n_i)) |=> insvc_o);

endmodule

bind irq_chain_node irq_chain_node_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .iei_i    (iei_i),
    .m1_n_i   (m1_n_i),
    .iorq_n_i (iorq_n_i),
    .rd_n_i   (rd_n_i),
    .reti_i   (reti_i),
    .vec_oe_o (vec_oe_o),
    .pend_o   (pend_o),
    .insvc_o  (insvc_o)
);

// File: tb/irq_chain_node_test.sv
`timescale 1ns/1ps
// Bench: three nodes in a chain, uut highest priority, n1 next, n2 lowest.
module irq_chain_node_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = 3'b000;
    logic       iei_top = 1'b1;
    logic       m1_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       reti = 1'b0;

    logic [2:0] ieo;
    logic [2:0] intn;
    logic [2:0] oe;
    logic [2:0] pend;
    logic [2:0] ins;
    logic [7:0] v0, v1, v2;
    logic [7:0] bus;
    logic       int_all;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    irq_chain_node #(.VEC_W(8), .VECTOR(8'h10)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req[0]), .iei_i(iei_top),
        .m1_n_i(m1_n), .iorq_n_i(iorq_n), .rd_n_i(rd_n), .reti_i(reti),
        .ieo_o(ieo[0]), .int_n_o(intn[0]), .vec_o(v0), .vec_oe_o(oe[0]),
        .pend_o(pend[0]), .insvc_o(ins[0]));

    irq_chain_node #(.VEC_W(8), .VECTOR(8'h20)) n1 (
        .clk(clk), .rst_n(rst_n), .req_i(req[1]), .iei_i(ieo[0]),
        .m1_n_i(m1_n), .iorq_n_i(iorq_n), .rd_n_i(rd_n), .reti_i(reti),
        .ieo_o(ieo[1]), .int_n_o(intn[1]), .vec_o(v1), .vec_oe_o(oe[1]),
        .pend_o(pend[1]), .insvc_o(ins[1]));

    irq_chain_node #(.VEC_W(8), .VECTOR(8'h30)) n2 (
        .clk(clk), .rst_n(rst_n), .req_i(req[2]), .iei_i(ieo[1]),
        .m1_n_i(m1_n), .iorq_n_i(iorq_n), .rd_n_i(rd_n), .reti_i(reti),
        .ieo_o(ieo[2]), .int_n_o(intn[2]), .vec_o(v2), .vec_oe_o(oe[2]),
        .pend_o(pend[2]), .insvc_o(ins[2]));

    assign bus     = v0 | v1 | v2;
    assign int_all = &intn;

    // Row: req[24:22] m1_n[21] iorq_n[20] rd_n[19] reti[18]
    //      pend[17:15] insvc[14:12] oe[11:9] int_n[8] bus[7:0]
    localparam int STEPS = 20;
    localparam logic [24:0] TBL [STEPS] = '{
        {3'b010, 4'b1110, 3'b010, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b100, 4'b1110, 3'b110, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b001, 4'b0110, 3'b110, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b000, 4'b0010, 3'b100, 3'b010, 3'b010, 1'b1, 8'h20},
        {3'b000, 4'b0010, 3'b100, 3'b010, 3'b010, 1'b1, 8'h20},
        {3'b000, 4'b1110, 3'b101, 3'b010, 3'b000, 1'b0, 8'h00},
        {3'b000, 4'b0010, 3'b100, 3'b011, 3'b001, 1'b1, 8'h10},
        {3'b000, 4'b1110, 3'b100, 3'b011, 3'b000, 1'b1, 8'h00},
        {3'b000, 4'b1111, 3'b100, 3'b010, 3'b000, 1'b1, 8'h00},
        {3'b000, 4'b0111, 3'b100, 3'b010, 3'b000, 1'b1, 8'h00},
        {3'b000, 4'b1111, 3'b100, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b000, 4'b0010, 3'b000, 3'b100, 3'b100, 1'b1, 8'h30},
        {3'b000, 4'b1111, 3'b000, 3'b000, 3'b000, 1'b1, 8'h00},
        {3'b010, 4'b1110, 3'b010, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b000, 4'b0000, 3'b010, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b000, 4'b1110, 3'b010, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b010, 4'b0010, 3'b000, 3'b010, 3'b010, 1'b1, 8'h20},
        {3'b000, 4'b1111, 3'b010, 3'b000, 3'b000, 1'b0, 8'h00},
        {3'b000, 4'b0010, 3'b000, 3'b010, 3'b010, 1'b1, 8'h20},
        {3'b000, 4'b1111, 3'b000, 3'b000, 3'b000, 1'b1, 8'h00}
    };

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    // Compare all outputs against one expected state
    task automatic check_all(input string tag, input logic [2:0] ep, input logic [2:0] ei,
                             input logic [2:0] eo, input logic eint, input logic [7:0] ebus);
        logic [2:0] eieo;
        eieo[0] = iei_top & ~ep[0] & ~ei[0];
        eieo[1] = eieo[0] & ~ep[1] & ~ei[1];
        eieo[2] = eieo[1] & ~ep[2] & ~ei[2];
        chk({tag, " R2/R7/R10 pend"}, {5'b0, pend}, {5'b0, ep});
        chk({tag, " R6/R8 insvc"}, {5'b0, ins}, {5'b0, ei});
        chk({tag, " R5/R9 vec_oe"}, {5'b0, oe}, {5'b0, eo});
        chk({tag, " R2 int_n"}, {7'b0, int_all}, {7'b0, eint});
        chk({tag, " R5 vector"}, bus, ebus);
        chk({tag, " R3/R4 ieo"}, {5'b0, ieo}, {5'b0, eieo});
    endtask

    // Drive one cycle of inputs, then sample after the edge
    task automatic step(input logic [2:0] r, input logic [3:0] strobes);
        @(negedge clk);
        req    = r;
        m1_n   = strobes[3];
        iorq_n = strobes[2];
        rd_n   = strobes[1];
        reti   = strobes[0];
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual %0d expected below 5000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) step(3'b000, 4'b1110);
        check_all("reset R1", 3'b000, 3'b000, 3'b000, 1'b1, 8'h00);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < STEPS; i++) begin
            step(TBL[i][24:22], TBL[i][21:18]);
            check_all($sformatf("step %0d", i), TBL[i][17:15], TBL[i][14:12],
                      TBL[i][11:9], TBL[i][8], TBL[i][7:0]);
        end

        // R2/R4: top enable low blocks interrupt but the node still blocks the chain
        iei_top = 1'b0;
        step(3'b001, 4'b1110);
        check_all("iei low req R2 R4", 3'b001, 3'b000, 3'b000, 1'b1, 8'h00);

        // R9: acknowledge with enable low is ignored
        step(3'b000, 4'b0010);
        check_all("iei low ack R9", 3'b001, 3'b000, 3'b000, 1'b1, 8'h00);
        step(3'b000, 4'b1110);

        // R2: enable returns, interrupt asserted
        iei_top = 1'b1;
        step(3'b000, 4'b1110);
        check_all("iei high R2", 3'b001, 3'b000, 3'b000, 1'b0, 8'h00);

        // R8: release while not in service leaves state unchanged
        step(3'b000, 4'b1111);
        check_all("idle reti R8", 3'b001, 3'b000, 3'b000, 1'b0, 8'h00);

        // R1: reset mid-operation clears and reopens the chain
        rst_n = 1'b0;
        step(3'b000, 4'b1110);
        check_all("mid reset R1", 3'b000, 3'b000, 3'b000, 1'b1, 8'h00);
        rst_n = 1'b1;
        step(3'b000, 4'b1110);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule